// File: doc/BRIEF.md
# Timer Interrupt Delivery and Status

This block sits between a set of timer channels and the interrupt fabric. Each channel produces single-cycle fire pulses. The block turns each pulse into one of three kinds of interrupt, according to that channel's configuration word: a one-cycle pulse on a numbered pin (edge), a held pin level with a status bit behind it (level), or a queued message request carrying a 32-bit address and a 32-bit data word.

Software programs each channel through a shared 32-bit configuration data bus with a one-hot write strobe. A second shared 64-bit bus with its own strobe loads the per-channel message register. A write-one-to-clear strobe vector acknowledges level interrupts. The block checks every pin route against a per-channel allowed-pin mask, which is derived from the number of pins the interrupt controller has. When a level interrupt is pending and a configuration change would leave its line stuck high, the block drops that pending interrupt by itself.

Top module: `timer_irq_router`

## Requirements
- R1: A fire pulse on a channel whose interrupt-enable bit (configuration bit 2) is 0 produces no pin pulse, no status bit and no message.
- R2: A channel uses message delivery only when it is message-capable (bit c of parameter MSG_CAP_MASK) and its message-enable bit (configuration bit 14) is 1. A channel in message delivery reports pin number 0 and never drives its line. A channel with message enable set but no message capability delivers on its pin.
- R3: The pin route is configuration bits 13:9. Route 0 means unrouted: a fire then produces neither a line pulse nor a status bit.
- R4: With the type bit (configuration bit 1) at 0, an accepted fire drives the channel line high for exactly the one cycle after the sampling edge and leaves the status bit at 0.
- R5: With the type bit at 1, an accepted fire sets the status bit and drives the line high from the next cycle. A further fire while the bit is set changes nothing.
- R6: A 1 on a channel's clear strobe clears a set status bit and drops that line on the same edge. A 0 on the strobe leaves the bit unchanged.
- R7: A route whose bit in the channel's allowed mask is 0 is stored as 0. The allowed mask is 0xFF000000 when PIN_COUNT >= 32, bits PIN_COUNT-4 to PIN_COUNT-1 when PIN_COUNT >= 20, and 0 otherwise (pins 20 to 23 for the default of 24).
- R8: A configuration write clears a set status bit and lowers its line when it disables the interrupt, selects edge or message delivery, or changes the effective pin. A write that keeps all of these the same leaves the bit set.
- R9: A message request is presented on a valid/ready handshake with address from message-register bits 63:32 and data from bits 31:0. While valid is high and ready is low, valid, address and data stay unchanged. Pending channels are served lowest index first.
- R10: After reset, all status bits, lines, reported pin numbers and the message valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fire_i | input | NCH | Per-channel fire pulses |
| cfg_we_i | input | NCH | One-hot configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration word (type bit 1, enable bit 2, route 13:9, message enable bit 14) |
| msg_we_i | input | NCH | One-hot message register write strobe |
| msg_wdata_i | input | 64 | Message register value (address 63:32, data 31:0) |
| sts_clr_i | input | NCH | Write-one-to-clear strobes for the status bits |
| irq_pin_o | output | NCH*5 | Effective pin number per channel, channel c at bits 5c+4:5c |
| irq_line_o | output | NCH | Per-channel interrupt line (level or pulse) |
| irq_status_o | output | NCH | Per-channel status bits |
| msg_valid_o | output | 1 | Message request valid |
| msg_ready_i | input | 1 | Message request accepted |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
The bench targets the configuration rewrites that must drop a pending level interrupt: route change, switch to edge, interrupt disable. It also rewrites an identical word, which must not drop it. A design that compared raw words or forgot one condition would either leave a line stuck high or lose a live interrupt. It also routes to a pin outside the allowed mask and sets message enable on a channel without message capability. Misreading either would put a pulse on a pin that may not be driven, or send a message that has nowhere to go. Finally, three message requests arrive together while ready is low. A wrong arbiter would change address mid-request or serve channels out of order, and the scoreboard queue catches both.

// File: rtl/tid_pkg.sv
package tid_pkg;

  localparam int ROUTE_W       = 5;
  localparam int CFG_W         = 32;
  localparam int MSG_W         = 64;
  localparam int CFG_TYPE_BIT  = 1;
  localparam int CFG_IE_BIT    = 2;
  localparam int CFG_ROUTE_LSB = 9;
  localparam int CFG_MSGEN_BIT = 14;

  typedef struct packed {
    logic               msg_en;
    logic [ROUTE_W-1:0] route;
    logic               ie;
    logic               level;
  } chan_cfg_t;

  function automatic logic [31:0] allowed_pins(input int pin_count);
    logic [31:0] m;
    if (pin_count >= 32)      m = 32'hFF00_0000;
    else if (pin_count >= 20) m = 32'h0000_000F << (pin_count - 4);
    else                      m = 32'h0;
    return m;
  endfunction

  function automatic chan_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    chan_cfg_t c;
    c.msg_en = w[CFG_MSGEN_BIT];
    c.route  = w[CFG_ROUTE_LSB +: ROUTE_W];
    c.ie     = w[CFG_IE_BIT];
    c.level  = w[CFG_TYPE_BIT];
    return c;
  endfunction

endpackage

// File: rtl/tid_channel.sv
module tid_channel
  import tid_pkg::*;
#(
  parameter logic [31:0] ALLOW_MASK  = 32'h0,
  parameter bit          MSG_CAPABLE = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire_i,
  input  logic               cfg_we_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  input  logic               msg_we_i,
  input  logic [MSG_W-1:0]   msg_wdata_i,
  input  logic               sts_clr_i,
  output logic [ROUTE_W-1:0] pin_o,
  output logic               line_o,
  output logic               status_o,
  output logic               msg_req_o,
  output logic [MSG_W-1:0]   msg_word_o
);

  chan_cfg_t          cfg_q, cfg_new;
  logic               status_q, status_d;
  logic               pulse_q, pulse_d;
  logic [MSG_W-1:0]   msg_q;
  logic               msg_mode_cur, msg_mode_new;
  logic [ROUTE_W-1:0] pin_cur, pin_new;
  logic               fire_ok, pin_fire, set_lvl, cfg_clear;

  // sanitize the requested route against the allowed mask
  always_comb begin
    cfg_new = unpack_cfg(cfg_wdata_i);
    if (cfg_new.route != '0 && !ALLOW_MASK[cfg_new.route]) cfg_new.route = '0;
  end

  always_comb begin
    msg_mode_cur = MSG_CAPABLE && cfg_q.msg_en;
    msg_mode_new = MSG_CAPABLE && cfg_new.msg_en;
    pin_cur      = msg_mode_cur ? '0 : cfg_q.route;
    pin_new      = msg_mode_new ? '0 : cfg_new.route;
    fire_ok      = fire_i && cfg_q.ie;
    msg_req_o    = fire_ok && msg_mode_cur;
    pin_fire     = fire_ok && !msg_mode_cur && (pin_cur != '0);
    pulse_d      = pin_fire && !cfg_q.level;
    set_lvl      = pin_fire && cfg_q.level;
    cfg_clear    = cfg_we_i && ((pin_cur == '0) || !cfg_new.ie || msg_mode_new ||
                                !cfg_new.level || (pin_new != pin_cur));
    status_d     = ((status_q && !sts_clr_i) || set_lvl) && !cfg_clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      status_q <= 1'b0;
      pulse_q  <= 1'b0;
      msg_q    <= '0;
    end else begin
      if (cfg_we_i) cfg_q <= cfg_new;
      if (msg_we_i) msg_q <= msg_wdata_i;
      status_q <= status_d;
      pulse_q  <= pulse_d;
    end
  end

  assign pin_o      = pin_cur;
  assign line_o     = status_q | pulse_q;
  assign status_o   = status_q;
  assign msg_word_o = msg_q;

  assert_drop_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !cfg_q.ie && !status_q && !msg_req_o) |=> (!pulse_q && !status_q));

  assert_route_allowed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.route != '0) |-> ALLOW_MASK[cfg_q.route]);

  assert_status_consistent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_q |-> (cfg_q.level && cfg_q.ie && !msg_mode_cur && pin_cur != '0));

  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && sts_clr_i && !fire_i) |=> !status_q);

endmodule

// File: rtl/tid_msg_arb.sv
module tid_msg_arb
  import tid_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       req_i,
  input  logic [NCH*MSG_W-1:0] word_i,
  input  logic                 ready_i,
  output logic                 valid_o,
  output logic [31:0]          addr_o,
  output logic [31:0]          data_o
);

  logic [NCH-1:0]   pend_q, pend_d, take;
  logic [MSG_W-1:0] sel_word, word_q;
  logic             valid_q, valid_d, load;

  // lowest index wins
  always_comb begin
    take     = '0;
    sel_word = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        take     = '0;
        take[i]  = 1'b1;
        sel_word = word_i[i*MSG_W +: MSG_W];
      end
    end
  end

  always_comb begin
    load    = !valid_q || ready_i;
    valid_d = load ? (|pend_q) : valid_q;
    pend_d  = (pend_q & ~(load ? take : '0)) | req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      pend_q  <= pend_d;
      valid_q <= valid_d;
      if (load && (|pend_q)) word_q <= sel_word;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = word_q[63:32];
  assign data_o  = word_q[31:0];

  assert_single_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));

  assert_hold_until_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(data_o)));

endmodule

// File: rtl/timer_irq_router.sv
module timer_irq_router
  import tid_pkg::*;
#(
  parameter int           NCH          = 8,
  parameter int           PIN_COUNT    = 24,
  parameter logic [NCH-1:0] MSG_CAP_MASK = 8'h0F
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         fire_i,
  input  logic [NCH-1:0]         cfg_we_i,
  input  logic [CFG_W-1:0]       cfg_wdata_i,
  input  logic [NCH-1:0]         msg_we_i,
  input  logic [MSG_W-1:0]       msg_wdata_i,
  input  logic [NCH-1:0]         sts_clr_i,
  output logic [NCH*ROUTE_W-1:0] irq_pin_o,
  output logic [NCH-1:0]         irq_line_o,
  output logic [NCH-1:0]         irq_status_o,
  output logic                   msg_valid_o,
  input  logic                   msg_ready_i,
  output logic [31:0]            msg_addr_o,
  output logic [31:0]            msg_data_o
);

  localparam logic [31:0] RESET_ALLOW = allowed_pins(PIN_COUNT);

  logic [NCH-1:0]       msg_req;
  logic [NCH*MSG_W-1:0] msg_words;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    tid_channel #(
      .ALLOW_MASK  (RESET_ALLOW),
      .MSG_CAPABLE (MSG_CAP_MASK[c])
    ) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .fire_i      (fire_i[c]),
      .cfg_we_i    (cfg_we_i[c]),
      .cfg_wdata_i (cfg_wdata_i),
      .msg_we_i    (msg_we_i[c]),
      .msg_wdata_i (msg_wdata_i),
      .sts_clr_i   (sts_clr_i[c]),
      .pin_o       (irq_pin_o[c*ROUTE_W +: ROUTE_W]),
      .line_o      (irq_line_o[c]),
      .status_o    (irq_status_o[c]),
      .msg_req_o   (msg_req[c]),
      .msg_word_o  (msg_words[c*MSG_W +: MSG_W])
    );
  end

  tid_msg_arb #(.NCH(NCH)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (msg_req),
    .word_i  (msg_words),
    .ready_i (msg_ready_i),
    .valid_o (msg_valid_o),
    .addr_o  (msg_addr_o),
    .data_o  (msg_data_o)
  );

  assert_msg_not_on_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_req != '0) |=> ((irq_line_o & $past(msg_req) & ~$past(irq_line_o)) == '0));

endmodule

// File: tb/test_timer_irq_router.sv
module test_timer_irq_router;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NCH-1:0]    fire, cfg_we, msg_we, sts_clr;
  logic [31:0]       cfg_wdata;
  logic [63:0]       msg_wdata;
  logic [NCH*5-1:0]  pin;
  logic [NCH-1:0]    line, status;
  logic              msg_valid, msg_ready;
  logic [31:0]       msg_addr, msg_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_irq_router i_timer_irq_router (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .cfg_we_i(cfg_we),
    .cfg_wdata_i(cfg_wdata), .msg_we_i(msg_we), .msg_wdata_i(msg_wdata),
    .sts_clr_i(sts_clr), .irq_pin_o(pin), .irq_line_o(line),
    .irq_status_o(status), .msg_valid_o(msg_valid), .msg_ready_i(msg_ready),
    .msg_addr_o(msg_addr), .msg_data_o(msg_data));

  function automatic logic [31:0] cfgw(bit lvl, bit ie, int route, bit men);
    return (32'(men) << 14) | (32'(route & 31) << 9) | (32'(ie) << 2) | (32'(lvl) << 1);
  endfunction

  function automatic logic [63:0] msgw(int ch);
    return {32'hFEE0_0000 + 32'(ch * 16), 32'h0000_0040 + 32'(ch)};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr_cfg(int ch, logic [31:0] w);
    cfg_we = '0; cfg_we[ch] = 1'b1; cfg_wdata = w;
    tick();
    cfg_we = '0;
  endtask

  task automatic wr_msg(int ch);
    msg_we = '0; msg_we[ch] = 1'b1; msg_wdata = msgw(ch);
    tick();
    msg_we = '0;
  endtask

  task automatic pulse_fire(logic [NCH-1:0] v);
    fire = v;
    tick();
    fire = '0;
  endtask

  task automatic pulse_clr(logic [NCH-1:0] v);
    sts_clr = v;
    tick();
    sts_clr = '0;
  endtask

  // scoreboard monitor: handshake completes at the following edge
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (expq.size() == 0) begin
        chk("R9 unexpected message", {msg_addr, msg_data}, 64'h0);
      end else begin
        logic [63:0] e;
        e = expq.pop_front();
        chk("R9 message addr/data", {msg_addr, msg_data}, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fire = '0; cfg_we = '0; msg_we = '0; sts_clr = '0;
    cfg_wdata = '0; msg_wdata = '0; msg_ready = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();

    // R10 reset state
    chk("R10 status", status, 0);
    chk("R10 line", line, 0);
    chk("R10 pins", pin, 0);
    chk("R10 msg valid", msg_valid, 0);

    // R5 level delivery on ch0, pin 20
    wr_cfg(0, cfgw(1, 1, 20, 0));
    chk("R3 pin number ch0", pin[4:0], 20);
    pulse_fire(8'h01);
    chk("R5 status set", status[0], 1);
    chk("R5 line high", line[0], 1);
    pulse_fire(8'h01);
    chk("R5 refire keeps status", status[0], 1);
    // R6 zero strobe has no effect
    pulse_clr(8'h02);
    chk("R6 zero strobe keeps status", status[0], 1);
    chk("R6 zero strobe keeps line", line[0], 1);
    pulse_clr(8'h01);
    chk("R6 clear status", status[0], 0);
    chk("R6 clear line", line[0], 0);

    // R4 edge delivery on ch1, pin 21
    wr_cfg(1, cfgw(0, 1, 21, 0));
    pulse_fire(8'h02);
    chk("R4 pulse high", line[1], 1);
    chk("R4 no status", status[1], 0);
    tick();
    chk("R4 pulse one cycle", line[1], 0);

    // R7 disallowed route is forced to 0; R3 unrouted gives nothing
    wr_cfg(2, cfgw(1, 1, 5, 0));
    chk("R7 route forced to 0", pin[14:10], 0);
    pulse_fire(8'h04);
    chk("R3 unrouted no status", status[2], 0);
    chk("R3 unrouted no line", line[2], 0);
    wr_cfg(2, cfgw(1, 1, 24, 0));
    chk("R7 pin above count forced to 0", pin[14:10], 0);

    // R1 disabled channel drops fires
    wr_cfg(3, cfgw(1, 0, 22, 0));
    pulse_fire(8'h08);
    chk("R1 no status", status[3], 0);
    chk("R1 no line", line[3], 0);
    wr_cfg(3, cfgw(0, 0, 22, 0));
    pulse_fire(8'h08);
    chk("R1 no edge pulse", line[3], 0);

    // R8 auto-clear on configuration change
    pulse_fire(8'h01);
    wr_cfg(0, cfgw(1, 1, 23, 0));
    chk("R8 route change clears", status[0], 0);
    chk("R8 route change lowers line", line[0], 0);
    pulse_fire(8'h01);
    wr_cfg(0, cfgw(0, 1, 23, 0));
    chk("R8 switch to edge clears", status[0], 0);
    wr_cfg(0, cfgw(1, 1, 23, 0));
    pulse_fire(8'h01);
    wr_cfg(0, cfgw(1, 0, 23, 0));
    chk("R8 disable clears", status[0], 0);
    wr_cfg(0, cfgw(1, 1, 23, 0));
    pulse_fire(8'h01);
    wr_cfg(0, cfgw(1, 1, 23, 0));
    chk("R8 identical write keeps", status[0], 1);
    pulse_clr(8'h01);

    // R2 capability gating: ch5 lacks it, ch2 has it
    wr_cfg(5, cfgw(1, 1, 20, 1));
    chk("R2 incapable keeps pin", pin[29:25], 20);
    pulse_fire(8'h20);
    chk("R2 incapable uses pin", status[5], 1);
    pulse_clr(8'h20);
    wr_msg(2);
    wr_cfg(2, cfgw(1, 1, 21, 1));
    chk("R2 message mode pin 0", pin[14:10], 0);
    expq.push_back(msgw(2));
    pulse_fire(8'h04);
    chk("R2 message no line", line[2], 0);
    chk("R2 message no status", status[2], 0);
    repeat (3) tick();
    chk("R2 message delivered", expq.size(), 0);

    // R9 back-pressure and priority
    wr_msg(0); wr_msg(3);
    wr_cfg(0, cfgw(0, 1, 0, 1));
    wr_cfg(3, cfgw(0, 1, 0, 1));
    msg_ready = 1'b0;
    expq.push_back(msgw(0));
    expq.push_back(msgw(2));
    expq.push_back(msgw(3));
    pulse_fire(8'h0D);
    repeat (3) tick();
    chk("R9 valid held", msg_valid, 1);
    chk("R9 lowest first held", {msg_addr, msg_data}, msgw(0));
    tick();
    chk("R9 still stable", {msg_addr, msg_data}, msgw(0));
    msg_ready = 1'b1;
    repeat (6) tick();
    chk("R9 all served in order", expq.size(), 0);
    chk("R9 valid drops", msg_valid, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule